// File: doc/BRIEF.md
# Fuse key readout controller

This block lets software fetch 32-bit words from a small one-time-programmable key array. The array sits behind a request/response interface and may take several cycles to answer. Software writes a command word into a control register. The word carries a word index, an unlock byte and a start bit. Software then polls the start bit until it drops and collects the fetched word from a result register. The final write of zero to the control register releases the lock.

A second path is a mirror window. Through it the bus reads key words directly, without running a command. A mirror entry holds nothing useful after reset. It is filled only when a register-driven read of that word completes successfully. A boot routine therefore walks every word once through the command path and uses the cheaper mirror reads from then on. The fuse side is guarded by a cycle timeout, so the start bit always clears within a bounded time even if the array never answers.

Top module: `fuse_key_rdctl`

## Requirements
- R1: After reset, the control register (byte offset 0x040) and the result register (byte offset 0x060) read zero, and every mirror word reads zero.
- R2: A write to the control register with bit 1 set, bits 15:8 equal to 0xAC and an in-range index in bits 24:16 is accepted. The block pulses `fuse_req` for exactly one cycle with `fuse_idx` equal to the index, and control bit 1 reads 1 from the cycle after the write until completion.
- R3: When `fuse_valid` is sampled high during a command, `fuse_data` is placed in the result register and control bit 1 reads 0 from the following cycle. With a fuse that answers L cycles after it sees the request, bit 1 clears L+2 cycles after the accepting write.
- R4: A control write with bit 1 set and bits 15:8 not equal to 0xAC is ignored. Bit 1 stays 0, no fuse request is made, and both the control register and the result register keep their previous values.
- R5: Writes to the control register while a command is in progress are ignored. The control register keeps the original index, and the command completes with the originally requested word.
- R6: An accepted command whose index is 64 or more makes no fuse request. It loads zero into the result register and clears bit 1 one cycle after the accepting write.
- R7: If the fuse does not answer within TIMEOUT_CYC (default 64) cycles of acceptance, the command completes with a zero result and bit 1 clears exactly TIMEOUT_CYC cycles after the accepting write.
- R8: Mirror word i at byte offset 0x200 + 4*i reads zero until a command for word i has completed with fuse data, and then reads that word. Out-of-range and timed-out commands leave the mirror unchanged.
- R9: An idle control write with bit 1 clear stores the written value, and the control register reads it back. Writing zero releases the block to idle with a zero control register.
- R10: Addresses in the 1 KiB space other than the control register, the result register and the aligned mirror words read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 10 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| fuse_req | output | 1 | One-cycle fetch request to the fuse array |
| fuse_idx | output | 6 | Key word index of the request |
| fuse_valid | input | 1 | Fuse array answer strobe |
| fuse_data | input | 32 | Fuse word delivered with `fuse_valid` |

## Verification
The bench goes after the unlock gate with wrong lock bytes. A design that checks only the start bit would raise a fuse request and overwrite the result. Commands are overwritten mid-flight, so that a design which re-latches the control register would fetch the wrong word. Out-of-range indices and a fuse that never answers are both used, and the bench counts the exact cycles until the start bit drops: a missing timeout hangs the poll, and a stale or unguarded mirror shows non-zero data for words never fetched. Random mixes of latencies and indices compare every mirror word against a model of which fetches completed.

// File: rtl/fkr_pkg.sv
package fkr_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_NULL = 2'd2
   } fkr_state_e;

   localparam int unsigned CMD_BIT  = 1;
   localparam int unsigned LOCK_LSB = 8;
   localparam int unsigned LOCK_W   = 8;
   localparam int unsigned IDX_LSB  = 16;

endpackage

// File: rtl/fkr_cmd.sv
module fkr_cmd
   import fkr_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned IDX_W       = 9,
   parameter int unsigned KEY_WORDS   = 64,
   parameter int unsigned TIMEOUT_CYC = 64,
   parameter logic [7:0]  LOCK_KEY    = 8'hAC,
   localparam int unsigned KIDX_W     = $clog2(KEY_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] ctrl_rd,
   output logic [DATA_W-1:0] result,
   output logic              busy,
   output logic              fuse_req,
   output logic [KIDX_W-1:0] fuse_idx,
   input  logic              fuse_valid,
   input  logic [DATA_W-1:0] fuse_data,
   output logic              mir_we,
   output logic [KIDX_W-1:0] mir_idx,
   output logic [DATA_W-1:0] mir_data
);

   localparam int unsigned TMO_W = $clog2(TIMEOUT_CYC);
   localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TIMEOUT_CYC - 1);
   localparam logic [IDX_W:0] IDX_LIMIT = (IDX_W + 1)'(KEY_WORDS);

   fkr_state_e        state_q;
   logic [DATA_W-1:0] ctrl_q;
   logic [TMO_W-1:0]  tmo_q;

   logic [IDX_W-1:0]  w_idx;
   logic [LOCK_W-1:0] w_lock;
   logic              w_go;
   logic              idle;
   logic              accept;
   logic              plain;
   logic              in_range;

   assign w_idx    = wdata[IDX_LSB +: IDX_W];
   assign w_lock   = wdata[LOCK_LSB +: LOCK_W];
   assign w_go     = wdata[CMD_BIT];
   assign idle     = (state_q == ST_IDLE);
   assign accept   = ctrl_we && idle && w_go && (w_lock == LOCK_KEY);
   assign plain    = ctrl_we && idle && !w_go;
   assign in_range = ({1'b0, w_idx} < IDX_LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         ctrl_q   <= '0;
         tmo_q    <= '0;
         result   <= '0;
         fuse_req <= 1'b0;
         fuse_idx <= '0;
      end else begin
         fuse_req <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  ctrl_q <= wdata;
                  tmo_q  <= '0;
                  if (in_range) begin
                     state_q  <= ST_WAIT;
                     fuse_req <= 1'b1;
                     fuse_idx <= w_idx[KIDX_W-1:0];
                  end else begin
                     state_q <= ST_NULL;
                  end
               end else if (plain) begin
                  ctrl_q <= wdata;
               end
            end
            ST_WAIT: begin
               if (fuse_valid) begin
                  result  <= fuse_data;
                  state_q <= ST_IDLE;
               end else if (tmo_q == TMO_LAST) begin
                  result  <= '0;
                  state_q <= ST_IDLE;
               end else begin
                  tmo_q <= tmo_q + 1'b1;
               end
            end
            ST_NULL: begin
               result  <= '0;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy     = !idle;
   assign mir_we   = (state_q == ST_WAIT) && fuse_valid;
   assign mir_idx  = fuse_idx;
   assign mir_data = fuse_data;

   always_comb begin
      ctrl_rd          = ctrl_q;
      ctrl_rd[CMD_BIT] = busy;
   end

   // R2: the fetch request is a single-cycle pulse issued only for a live command
   p_req_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fuse_req |=> !fuse_req);
   p_req_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fuse_req |-> busy);

   // R4: wrong unlock byte leaves the block idle and the result untouched
   p_bad_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_we && idle && w_go && (w_lock != LOCK_KEY))
      |=> (!busy && !fuse_req && $stable(result) && $stable(ctrl_rd)));

   // R5: a write while busy does not disturb the latched command word
   p_busy_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_we && busy) |=> $stable(ctrl_q));

   // R6: out-of-range command completes next cycle with zero data
   p_null_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_NULL) |=> (!busy && result == '0 && !fuse_req));

endmodule

// File: rtl/fkr_mirror.sv
module fkr_mirror #(
   parameter int unsigned DATA_W         = 32,
   parameter int unsigned KEY_WORDS      = 64,
   parameter bit          SCRUB_ON_RESET = 1'b1,
   localparam int unsigned KIDX_W        = $clog2(KEY_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [KIDX_W-1:0] wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [KIDX_W-1:0] rd_idx,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0]    mem_q [KEY_WORDS];
   logic [KEY_WORDS-1:0] vld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else if (wr_en) begin
         vld_q[wr_idx] <= 1'b1;
      end
   end

   generate
      if (SCRUB_ON_RESET) begin : g_scrub
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < KEY_WORDS; i++) mem_q[i] <= '0;
            end else if (wr_en) begin
               mem_q[wr_idx] <= wr_data;
            end
         end
      end else begin : g_noscrub
         always_ff @(posedge clk) begin
            if (wr_en) mem_q[wr_idx] <= wr_data;
         end
      end
   endgenerate

   assign rd_data = vld_q[rd_idx] ? mem_q[rd_idx] : '0;

   // R8: a completed fetch fills exactly the addressed mirror word
   p_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (vld_q[$past(wr_idx)] && mem_q[$past(wr_idx)] == $past(wr_data)));

endmodule

// File: rtl/fkr_bus_dec.sv
module fkr_bus_dec #(
   parameter int unsigned ADDR_W    = 10,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned KEY_WORDS = 64,
   parameter logic [ADDR_W-1:0] CTRL_OFF = 10'h040,
   parameter logic [ADDR_W-1:0] RSLT_OFF = 10'h060,
   parameter logic [ADDR_W-1:0] MIR_OFF  = 10'h200,
   localparam int unsigned KIDX_W = $clog2(KEY_WORDS)
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] ctrl_rd,
   input  logic [DATA_W-1:0] result,
   input  logic [DATA_W-1:0] mir_rdata,
   output logic              ctrl_sel,
   output logic [KIDX_W-1:0] mir_idx,
   output logic [DATA_W-1:0] rdata
);

   localparam logic [ADDR_W:0] MIR_END = (ADDR_W + 1)'(MIR_OFF) + (ADDR_W + 1)'(4 * KEY_WORDS);

   logic              rslt_sel;
   logic              mir_sel;
   logic [ADDR_W-1:0] mir_rel;

   assign ctrl_sel = (addr == CTRL_OFF);
   assign rslt_sel = (addr == RSLT_OFF);
   assign mir_rel  = addr - MIR_OFF;
   assign mir_sel  = (addr >= MIR_OFF) && ({1'b0, addr} < MIR_END) && (addr[1:0] == 2'b00);
   assign mir_idx  = mir_rel[KIDX_W+1:2];

   always_comb begin
      rdata = '0;
      if (ctrl_sel)      rdata = ctrl_rd;
      else if (rslt_sel) rdata = result;
      else if (mir_sel)  rdata = mir_rdata;
   end

endmodule

// File: rtl/fuse_key_rdctl.sv
module fuse_key_rdctl
   import fkr_pkg::*;
#(
   parameter int unsigned ADDR_W         = 10,
   parameter int unsigned DATA_W         = 32,
   parameter int unsigned IDX_W          = 9,
   parameter int unsigned KEY_WORDS      = 64,
   parameter int unsigned TIMEOUT_CYC    = 64,
   parameter logic [7:0]  LOCK_KEY       = 8'hAC,
   parameter logic [ADDR_W-1:0] CTRL_OFF = 10'h040,
   parameter logic [ADDR_W-1:0] RSLT_OFF = 10'h060,
   parameter logic [ADDR_W-1:0] MIR_OFF  = 10'h200,
   parameter bit          SCRUB_ON_RESET = 1'b1,
   localparam int unsigned KIDX_W        = $clog2(KEY_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              fuse_req,
   output logic [KIDX_W-1:0] fuse_idx,
   input  logic              fuse_valid,
   input  logic [DATA_W-1:0] fuse_data
);

   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("fuse_key_rdctl: DATA_W must be 32");
      end
      if ((1 << KIDX_W) != KEY_WORDS) begin : g_bad_depth
         $error("fuse_key_rdctl: KEY_WORDS must be a power of two");
      end
      if (KEY_WORDS >= (1 << IDX_W)) begin : g_bad_idx
         $error("fuse_key_rdctl: index field too narrow for KEY_WORDS");
      end
      if (IDX_LSB + IDX_W > DATA_W) begin : g_bad_field
         $error("fuse_key_rdctl: index field exceeds control word");
      end
      if (int'(MIR_OFF) + 4 * KEY_WORDS > (1 << ADDR_W)) begin : g_bad_map
         $error("fuse_key_rdctl: mirror window exceeds address space");
      end
      if (TIMEOUT_CYC < 2) begin : g_bad_tmo
         $error("fuse_key_rdctl: TIMEOUT_CYC must be at least 2");
      end
   endgenerate

   logic              ctrl_sel;
   logic [DATA_W-1:0] ctrl_rd;
   logic [DATA_W-1:0] result;
   logic              busy;
   logic              mir_we;
   logic [KIDX_W-1:0] mir_widx;
   logic [DATA_W-1:0] mir_wdata;
   logic [KIDX_W-1:0] mir_ridx;
   logic [DATA_W-1:0] mir_rdata;

   fkr_cmd #(
      .DATA_W      (DATA_W),
      .IDX_W       (IDX_W),
      .KEY_WORDS   (KEY_WORDS),
      .TIMEOUT_CYC (TIMEOUT_CYC),
      .LOCK_KEY    (LOCK_KEY)
   ) u_cmd (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctrl_we    (bus_we && ctrl_sel),
      .wdata      (bus_wdata),
      .ctrl_rd    (ctrl_rd),
      .result     (result),
      .busy       (busy),
      .fuse_req   (fuse_req),
      .fuse_idx   (fuse_idx),
      .fuse_valid (fuse_valid),
      .fuse_data  (fuse_data),
      .mir_we     (mir_we),
      .mir_idx    (mir_widx),
      .mir_data   (mir_wdata)
   );

   fkr_mirror #(
      .DATA_W         (DATA_W),
      .KEY_WORDS      (KEY_WORDS),
      .SCRUB_ON_RESET (SCRUB_ON_RESET)
   ) u_mirror (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (mir_we),
      .wr_idx  (mir_widx),
      .wr_data (mir_wdata),
      .rd_idx  (mir_ridx),
      .rd_data (mir_rdata)
   );

   fkr_bus_dec #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .KEY_WORDS (KEY_WORDS),
      .CTRL_OFF  (CTRL_OFF),
      .RSLT_OFF  (RSLT_OFF),
      .MIR_OFF   (MIR_OFF)
   ) u_dec (
      .addr      (bus_addr),
      .ctrl_rd   (ctrl_rd),
      .result    (result),
      .mir_rdata (mir_rdata),
      .ctrl_sel  (ctrl_sel),
      .mir_idx   (mir_ridx),
      .rdata     (bus_rdata)
   );

   // R7: independent age counter bounds the time a command can stay busy
   localparam int unsigned AGE_W = $clog2(TIMEOUT_CYC + 4) + 1;
   logic [AGE_W-1:0] busy_age_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_age_q <= '0;
      else if (busy) busy_age_q <= busy_age_q + 1'b1;
      else           busy_age_q <= '0;
   end

   p_busy_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (busy_age_q <= AGE_W'(TIMEOUT_CYC)));

   // R3: a fuse answer during a command ends it on the next cycle
   p_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && fuse_valid) |=> (!busy && result == $past(fuse_data)));

endmodule

// File: tb/fuse_key_rdctl_tb.sv
`timescale 1ns/1ps
module fuse_key_rdctl_tb;

   localparam int TMO   = 64;
   localparam int WORDS = 64;
   localparam logic [9:0] A_CTRL = 10'h040;
   localparam logic [9:0] A_RSLT = 10'h060;
   localparam logic [9:0] A_MIR  = 10'h200;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        fuse_req;
   logic [5:0]  fuse_idx;
   logic        fuse_valid = 1'b0;
   logic [31:0] fuse_data = '0;

   int errs = 0;
   int checks = 0;
   int lat_cfg = 2;
   bit drop_cfg = 1'b0;
   int req_cnt = 0;

   logic [31:0] exp_mir [WORDS];
   bit          exp_vld [WORDS];
   logic [31:0] exp_res = '0;

   always #2 clk = ~clk;

   fuse_key_rdctl #(.TIMEOUT_CYC(TMO)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fuse_req(fuse_req),
      .fuse_idx(fuse_idx), .fuse_valid(fuse_valid), .fuse_data(fuse_data)
   );

   function automatic logic [31:0] fw(int i);
      return (32'(i) * 32'h9E3779B1) ^ 32'hC3A50F1E;
   endfunction

   // behavioural fuse array with per-request latency
   bit         pend = 1'b0;
   int         pcnt = 0;
   logic [5:0] pidx = '0;
   always @(posedge clk) begin
      fuse_valid <= 1'b0;
      if (pend) begin
         if (pcnt == 0) begin
            fuse_valid <= 1'b1;
            fuse_data  <= fw(int'(pidx));
            pend       <= 1'b0;
         end else begin
            pcnt <= pcnt - 1;
         end
      end
      if (fuse_req) begin
         req_cnt <= req_cnt + 1;
         if (!drop_cfg) begin
            pend <= 1'b1;
            pcnt <= lat_cfg - 1;
            pidx <= fuse_idx;
         end
      end
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [9:0] a, logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(logic [9:0] a, output logic [31:0] d);
      bus_addr = a;
      #0.5;
      d = bus_rdata;
   endtask

   function automatic logic [31:0] cmd(int idx, logic [7:0] lock);
      return (32'(idx) << 16) | (32'(lock) << 8) | 32'h2;
   endfunction

   // one command; mode 0 normal, 1 fuse never answers
   task automatic do_read(int idx, int lat, bit drop);
      logic [31:0] v;
      int polls;
      int req0;
      bit oor;
      oor = (idx >= WORDS);
      lat_cfg = lat; drop_cfg = drop;
      req0 = req_cnt;
      wr(A_CTRL, cmd(idx, 8'hAC));
      rd(A_CTRL, v);
      chk("R2 busy bit after accept", 32'(v[1]), 32'd1);
      chk("R2 index held in control", 32'(v[24:16]), 32'(idx));
      polls = 0;
      for (int k = 0; k < TMO + 10; k++) begin
         @(negedge clk);
         polls++;
         rd(A_CTRL, v);
         if (v[1] == 1'b0) break;
      end
      if (oor) begin
         chk("R6 done one cycle after accept", 32'(polls), 32'd1);
         chk("R6 no fuse request", 32'(req_cnt - req0), 32'd0);
         exp_res = '0;
      end else if (drop) begin
         chk("R7 timeout cycle count", 32'(polls), 32'(TMO));
         chk("R2 one fuse request", 32'(req_cnt - req0), 32'd1);
         exp_res = '0;
      end else begin
         chk("R3 completion latency", 32'(polls), 32'(lat + 2));
         chk("R2 one fuse request", 32'(req_cnt - req0), 32'd1);
         exp_res = fw(idx);
         exp_mir[idx] = fw(idx);
         exp_vld[idx] = 1'b1;
      end
      rd(A_RSLT, v);
      chk(oor ? "R6 zero result" : (drop ? "R7 zero result" : "R3 result word"), v, exp_res);
      if (!oor) begin
         rd(A_MIR + 10'(4 * idx), v);
         chk(drop ? "R7 mirror untouched" : "R8 mirror filled", v,
             exp_vld[idx] ? exp_mir[idx] : 32'h0);
      end
      drop_cfg = 1'b0;
      wr(A_CTRL, 32'h0);
      rd(A_CTRL, v);
      chk("R9 release reads zero", v, 32'h0);
   endtask

   task automatic check_mirror_all();
      logic [31:0] v;
      for (int i = 0; i < WORDS; i++) begin
         rd(A_MIR + 10'(4 * i), v);
         chk("R8 mirror word", v, exp_vld[i] ? exp_mir[i] : 32'h0);
      end
   endtask

   task automatic bad_lock(logic [7:0] lock, int idx);
      logic [31:0] v;
      logic [31:0] c0;
      int req0;
      req0 = req_cnt;
      rd(A_CTRL, c0);
      wr(A_CTRL, cmd(idx, lock));
      rd(A_CTRL, v);
      chk("R4 control unchanged", v, c0);
      repeat (8) @(negedge clk);
      chk("R4 no fuse request", 32'(req_cnt - req0), 32'd0);
      rd(A_RSLT, v);
      chk("R4 result unchanged", v, exp_res);
   endtask

   task automatic busy_overwrite(int a, int b);
      logic [31:0] v;
      int req0;
      req0 = req_cnt;
      lat_cfg = 12;
      wr(A_CTRL, cmd(a, 8'hAC));
      wr(A_CTRL, cmd(b, 8'hAC));
      wr(A_CTRL, 32'h0);
      rd(A_CTRL, v);
      chk("R5 index kept while busy", 32'(v[24:16]), 32'(a));
      chk("R5 still busy", 32'(v[1]), 32'd1);
      for (int k = 0; k < TMO + 10; k++) begin
         @(negedge clk);
         rd(A_CTRL, v);
         if (v[1] == 1'b0) break;
      end
      chk("R5 completes", 32'(v[1]), 32'd0);
      chk("R5 single request", 32'(req_cnt - req0), 32'd1);
      exp_res = fw(a); exp_mir[a] = fw(a); exp_vld[a] = 1'b1;
      rd(A_RSLT, v);
      chk("R5 original word fetched", v, exp_res);
      wr(A_CTRL, 32'h0);
   endtask

   initial begin
      #(4 * 150000);
      errs++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int op;
      void'($urandom(32'd20250117));
      for (int i = 0; i < WORDS; i++) begin exp_mir[i] = '0; exp_vld[i] = 1'b0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(A_CTRL, v); chk("R1 control reset", v, 32'h0);
      rd(A_RSLT, v); chk("R1 result reset", v, 32'h0);
      check_mirror_all();

      // R10 unmapped addresses
      rd(10'h000, v); chk("R10 unmapped 0x000", v, 32'h0);
      rd(10'h044, v); chk("R10 unmapped 0x044", v, 32'h0);
      rd(10'h1FC, v); chk("R10 unmapped 0x1FC", v, 32'h0);
      rd(10'h300, v); chk("R10 unmapped 0x300", v, 32'h0);
      rd(10'h3FC, v); chk("R10 unmapped 0x3FC", v, 32'h0);
      rd(10'h201, v); chk("R10 unaligned mirror", v, 32'h0);

      // directed corners
      do_read(0, 1, 1'b0);
      do_read(63, 4, 1'b0);
      bad_lock(8'hAB, 5);
      bad_lock(8'h00, 7);
      do_read(64, 1, 1'b0);
      do_read(511, 1, 1'b0);
      do_read(9, 1, 1'b1);
      busy_overwrite(17, 18);

      // R9 plain write read-back
      wr(A_CTRL, 32'h00AB_1200);
      rd(A_CTRL, v); chk("R9 plain write stored", v, 32'h00AB_1200);
      wr(A_CTRL, 32'h0);

      // constrained random mix
      for (int it = 0; it < 120; it++) begin
         op = $urandom_range(0, 9);
         if (op <= 5) begin
            do_read($urandom_range(0, 79), $urandom_range(1, 6), 1'b0);
         end else if (op == 6) begin
            logic [7:0] lk;
            lk = 8'($urandom_range(0, 255));
            if (lk == 8'hAC) lk = 8'hAD;
            bad_lock(lk, $urandom_range(0, 63));
         end else if (op == 7) begin
            int w;
            w = $urandom_range(0, WORDS - 1);
            rd(A_MIR + 10'(4 * w), v);
            chk("R8 random mirror probe", v, exp_vld[w] ? exp_mir[w] : 32'h0);
         end else if (op == 8) begin
            logic [31:0] pv;
            pv = $urandom() & ~32'h2;
            wr(A_CTRL, pv);
            rd(A_CTRL, v); chk("R9 random plain write", v, pv);
            wr(A_CTRL, 32'h0);
         end else begin
            do_read($urandom_range(0, 63), 1, 1'b1);
         end
      end

      check_mirror_all();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule